// File: doc/BRIEF.md
# Stream-Fed Serial Byte Transmitter

This block takes bytes from a valid/ready stream sink and sends each one on a single serial output line. Every frame is 8N1: one low start bit, then eight data bits with the least significant bit first, then one high stop bit. The sink takes a byte only in a cycle where valid and ready are both high. The byte goes into an internal shift register, so the source may change or withdraw its data from the next cycle on.

Bit timing does not come from an integer divider. It comes from a 32-bit phase accumulator. Each busy clock adds a tuning word equal to baud / f_clk · 2^32, and every carry out of the accumulator ends one bit period. This gives an average bit rate that tracks fractional ratios. For example, 115200 baud from a 50 MHz clock uses the word 9895604.

The accumulator is cleared when a byte is accepted, so every frame starts at the same phase. Ready rises again in the cycle after the stop bit ends. A source that holds valid high therefore has its next byte accepted at once, and the next start bit follows one clock later.

Top module: `serial_stream_tx`

## Requirements
- R1: While reset is high and in the first cycle after it, `tx_line` is 1 and `snk_ready` is 1.
- R2: A cycle with `snk_valid` = 1 while `snk_ready` = 0 has no effect: the frame in progress and the state of the line are unchanged, and the offered byte is never sent.
- R3: When `snk_valid` and `snk_ready` are both 1 at a clock edge, the next cycle shows `snk_ready` = 0 and `tx_line` = 0 (the start bit).
- R4: While a frame is in progress, each clock adds `tune_word` to a 32-bit phase that was cleared to 0 at acceptance. Every carry out of bit 31 is one bit tick. The first possible tick is in the second cycle after acceptance.
- R5: Between two bit ticks, `tx_line` does not change.
- R6: The frame on `tx_line` is a start bit of 0, then the data bits d0 to d7 (LSB first), then a stop bit of 1. Each bit lasts until the next tick, so a frame spans ten ticks.
- R7: In the cycle after the tenth tick, `snk_ready` is 1 and `tx_line` is 1. Whenever `snk_ready` is 1, `tx_line` is 1.
- R8: If `snk_valid` is held high across the end of a frame, the next byte is accepted in the first cycle in which `snk_ready` is 1. Its start bit appears in the cycle after that.
- R9: Changes to `snk_data` after the accepting edge do not alter the frame being sent.
- R10: With `tune_word` = 9895604 (115200 baud at 50 MHz), a frame has the timing given by R4 and R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snk_valid | input | 1 | Stream sink: byte offered |
| snk_ready | output | 1 | Stream sink: transmitter can take a byte |
| snk_data | input | 8 | Stream sink: byte payload |
| tune_word | input | 32 | Phase increment per clock, baud / f_clk · 2^32 |
| tx_line | output | 1 | Serial output, idles high |

## Verification
The assertions assume that `tune_word` is below 2^32 and non-zero while a frame is in progress. They also assume that reset is held high from time zero until the first clock edges have passed. The stimulus sets `tune_word` only while the line is idle and uses only non-zero values. It offers bytes to the sink only at clock edges, and it deliberately drives `snk_valid` and `snk_data` while `snk_ready` is low to show that such cycles are ignored.

// File: rtl/sbtx_pkg.sv
package sbtx_pkg;
  localparam int unsigned DATA_BITS  = 8;
  localparam int unsigned PHASE_BITS = 32;
  localparam int unsigned FRAME_LEN  = DATA_BITS + 2;
  localparam int unsigned LEFT_BITS  = $clog2(FRAME_LEN + 1);

  typedef logic [DATA_BITS-1:0]  byte_t;
  typedef logic [PHASE_BITS-1:0] phase_t;
  typedef logic [LEFT_BITS-1:0]  left_t;
endpackage

// File: rtl/sbtx_phase_gen.sv
module sbtx_phase_gen #(
  parameter int unsigned PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               clear,
  input  logic [PHASE_W-1:0] step,
  output logic               tick
);
  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W:0]   sum;

  assign sum  = {1'b0, phase_q} + {1'b0, step};
  assign tick = run & sum[PHASE_W];

  always_ff @(posedge clk) begin
    if (rst || clear) phase_q <= '0;
    else if (run)     phase_q <= sum[PHASE_W-1:0];
  end

  // R4: acceptance restarts the phase at zero
  p_clear_zero_r4: assert property (@(posedge clk) disable iff (rst)
    clear |=> phase_q == '0);
  // R4: a tick is a wrap of the phase
  p_tick_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && !clear) |=> phase_q < $past(phase_q));
  // R4: phase frozen while no frame runs
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!run && !clear) |=> $stable(phase_q));
endmodule

// File: rtl/sbtx_frame_seq.sv
module sbtx_frame_seq #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              tick,
  output logic              in_ready,
  output logic              accept,
  output logic              tx
);
  localparam int unsigned FRAME_N = DATA_W + 2;
  localparam int unsigned CNT_W   = $clog2(FRAME_N + 1);

  logic              ready_q;
  logic              tx_q;
  logic [DATA_W:0]   shreg_q;
  logic [CNT_W-1:0]  left_q;

  assign accept   = in_valid & ready_q;
  assign in_ready = ready_q;
  assign tx       = tx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b1;
      tx_q    <= 1'b1;
      shreg_q <= '1;
      left_q  <= '0;
    end else if (accept) begin
      ready_q <= 1'b0;
      tx_q    <= 1'b0;
      shreg_q <= {1'b1, in_data};
      left_q  <= CNT_W'(FRAME_N);
    end else if (!ready_q && tick) begin
      if (left_q == CNT_W'(1)) begin
        ready_q <= 1'b1;
        tx_q    <= 1'b1;
        left_q  <= '0;
      end else begin
        tx_q    <= shreg_q[0];
        shreg_q <= {1'b1, shreg_q[DATA_W:1]};
        left_q  <= left_q - CNT_W'(1);
      end
    end
  end

  // R3: handshake leads to a start bit and a busy sink
  p_start_bit_r3: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!tx_q && !ready_q));
  // R5: line holds between ticks
  p_line_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!ready_q && !tick) |=> $stable(tx_q));
  // R2: offers during a frame leave the frame state alone
  p_busy_ignore_r2: assert property (@(posedge clk) disable iff (rst)
    (!ready_q && !tick) |=> ($stable(shreg_q) && $stable(left_q)));
  // R7: idle line is high
  p_idle_high_r7: assert property (@(posedge clk) disable iff (rst)
    ready_q |-> tx_q);
  // R7: release only after the last bit of the frame
  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_q) |-> $past(left_q) == CNT_W'(1));
endmodule

// File: rtl/serial_stream_tx.sv
module serial_stream_tx
  import sbtx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        snk_valid,
  output logic        snk_ready,
  input  logic [7:0]  snk_data,
  input  logic [31:0] tune_word,
  output logic        tx_line
);
  logic tick;
  logic accept;
  logic ready_int;

  sbtx_phase_gen #(.PHASE_W(PHASE_BITS)) u_phase (
    .clk   (clk),
    .rst   (rst),
    .run   (!ready_int),
    .clear (accept),
    .step  (tune_word),
    .tick  (tick)
  );

  sbtx_frame_seq #(.DATA_W(DATA_BITS)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .in_valid (snk_valid),
    .in_data  (snk_data),
    .tick     (tick),
    .in_ready (ready_int),
    .accept   (accept),
    .tx       (tx_line)
  );

  assign snk_ready = ready_int;

  // R1: reset leaves an idle, ready line
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (snk_ready && tx_line));
endmodule

// File: tb/serial_stream_tx_bench.sv
module serial_stream_tx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        snk_valid = 1'b0;
  logic [7:0]  snk_data = 8'h00;
  logic [31:0] tune_word = 32'h8000_0000;
  logic        snk_ready;
  logic        tx_line;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit cmp_en = 1'b0;
  string cur_req = "R1";

  serial_stream_tx u_serial_stream_tx (
    .clk(clk), .rst(rst), .snk_valid(snk_valid), .snk_ready(snk_ready),
    .snk_data(snk_data), .tune_word(tune_word), .tx_line(tx_line)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cycles);
    end
  endtask

  // behavioural reference: queue of pending line levels plus a phase integer
  bit      m_ready = 1'b1;
  bit      m_tx = 1'b1;
  longint  m_phase = 0;
  int      m_bits[$];

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_ready = 1'b1; m_tx = 1'b1; m_phase = 0; m_bits.delete();
    end else if (m_ready && snk_valid) begin
      m_ready = 1'b0; m_tx = 1'b0; m_phase = 0; m_bits.delete();
      for (int i = 0; i < 8; i++) m_bits.push_back(int'(snk_data[i]));
      m_bits.push_back(1);
    end else if (!m_ready) begin
      longint s;
      s = m_phase + longint'(tune_word);
      m_phase = s % (64'd1 << 32);
      if (s >= (64'd1 << 32)) begin
        if (m_bits.size() == 0) begin
          m_ready = 1'b1; m_tx = 1'b1;
        end else m_tx = m_bits.pop_front() != 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && cmp_en) begin
      chk(cur_req, "tx_line", tx_line, m_tx);
      chk(cur_req, "snk_ready", snk_ready, m_ready);
    end
  end

  task automatic wait_idle();
    while (!snk_ready) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d, input bit hold);
    snk_valid = 1'b1;
    snk_data  = d;
    while (!snk_ready) @(negedge clk);
    @(negedge clk);
    if (!hold) snk_valid = 1'b0;
    snk_data = ~d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "tx_line in reset", tx_line, 1);
    chk("R1", "snk_ready in reset", snk_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "tx_line after reset", tx_line, 1);
    chk("R1", "snk_ready after reset", snk_ready, 1);
    cmp_en = 1'b1;

    cur_req = "R3 R4 R5 R6 R7";
    tune_word = 32'h8000_0000;
    push(8'hA5, 1'b0);
    chk("R3", "start bit", tx_line, 0);
    chk("R3", "ready low", snk_ready, 0);
    wait_idle();
    chk("R7", "idle high after frame", tx_line, 1);

    cur_req = "R2 R9 R4";
    tune_word = 32'h5555_5556;
    push(8'h3C, 1'b0);
    snk_data = 8'hFF;
    snk_valid = 1'b1;
    repeat (3) @(negedge clk);
    snk_valid = 1'b0;
    snk_data = 8'h00;
    wait_idle();

    cur_req = "R8 R6";
    tune_word = 32'h4000_0000;
    push(8'h01, 1'b1);
    push(8'h80, 1'b0);
    chk("R8", "second start bit", tx_line, 0);
    wait_idle();
    repeat (4) @(negedge clk);

    cur_req = "R10";
    tune_word = 32'd9895604;
    push(8'h55, 1'b0);
    wait_idle();
    repeat (4) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired at cycle %0d", cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule